// File: doc/BRIEF.md
# Equipment Clock Mode Controller with Holdover

This block chooses the frequency control word that drives a digitally controlled oscillator in an equipment clock. While a good timing reference is present and the recovery loop reports lock, the live word from the loop filter passes through to the oscillator. While it tracks, the block keeps a long-term average of that word. If the reference is later lost, the block steers the oscillator with that average instead. This holds the clock close to the last good frequency and avoids a jump to a fixed value.

Holdover runs for a limited time. The limit is a programmable number of timebase ticks. When it runs out, the stored average is treated as stale and the block falls back to a fixed nominal word. A clock that has no usable average when the reference goes away also falls back to the nominal word. The block returns to tracking only after lock has been seen on a run of consecutive ticks. On that return the output does not jump: it walks toward the live word by a bounded amount per tick.

Top module: `clk_mode_ctrl`

## Requirements
- R1: `mode` uses this encoding: 2'b00 free-run, 2'b01 normal, 2'b10 holdover. The value 2'b11 never appears. After reset the block is in free-run.
- R2: Free-run or holdover changes to normal only after `ref_ok` and `lock_in` have both been high through LOCK (16) consecutive ticks. Any clock cycle in which either of them is low restarts the count. After the 16th tick, `mode` reads normal two clock edges later.
- R3: When `ref_ok` drops in normal mode, the block enters holdover only if the history is valid. If it is not valid, the block enters free-run. Holdover is never entered from free-run.
- R4: On each tick in normal mode with `ref_ok` high, the block updates a stored average that carries S (8) fraction bits. The first update after the history was cleared loads the word exactly. Each later update adds (word·2^S − avg) arithmetically shifted right by S. In holdover, `freq_word` equals the integer part of the average.
- R5: The history becomes valid after HIST (256) updates. If the reference is lost after only 255 updates, the block goes to free-run.
- R6: In holdover, the tick that makes the number of holdover ticks reach `hold_limit` moves the block to free-run. That transition clears the history, so 256 new updates are needed before holdover can be entered again.
- R7: In free-run, `freq_word` equals the nominal word (parameter NOMINAL, default 24'h800000).
- R8: On entry to normal, `freq_word` keeps its previous value. It then moves toward `loop_word` only on ticks, by `slew_step` per tick, and lands exactly on `loop_word` when the remaining gap is no larger than the step. A `slew_step` of 0 makes the output take `loop_word` on the next clock without waiting for a tick.
- R9: Once the slew has finished, `freq_word` follows `loop_word` with one register of latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_ok | input | 1 | Reference present and valid |
| lock_in | input | 1 | Recovery loop reports lock |
| tick | input | 1 | One-cycle timebase strobe |
| loop_word | input | W | Live frequency word from the loop filter |
| hold_limit | input | LIM_W | Holdover duration in ticks |
| slew_step | input | W | Maximum output change per tick while re-entering normal |
| freq_word | output | W | Selected oscillator frequency word |
| mode | output | 2 | Current mode code |

## Verification
On every cycle, the assertions check the rules for mode changes. Normal is entered only from a full lock count. Holdover is entered only from normal with valid history. Leaving holdover on timeout clears the history. A loss of reference without history leads to free-run. The assertions also check that free-run holds the nominal word and that the output never moves by more than one step per tick while slewing. Only the bench scenarios can show numerical correctness. These scenarios cover the exact averaged value presented in holdover and the exact tick at which each swept holdover limit expires. They also cover the cycle-by-cycle slew trajectory for several step sizes in both directions, and the off-by-one edges at 15 and 16 lock ticks and at 255 and 256 updates.

// File: rtl/clk_mode_ctrl.sv
module clk_mode_ctrl #(
  parameter int W = 24,
  parameter int S = 8,
  parameter int HIST = 256,
  parameter int LOCK = 16,
  parameter int LIM_W = 16,
  parameter logic [W-1:0] NOMINAL = 24'h800000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_ok,
  input  logic             lock_in,
  input  logic             tick,
  input  logic [W-1:0]     loop_word,
  input  logic [LIM_W-1:0] hold_limit,
  input  logic [W-1:0]     slew_step,
  output logic [W-1:0]     freq_word,
  output logic [1:0]       mode
);

  localparam int A    = W + S;
  localparam int HC_W = $clog2(HIST + 1);
  localparam int LC_W = $clog2(LOCK + 1);

  typedef enum logic [1:0] {M_FREE = 2'b00, M_NORM = 2'b01, M_HOLD = 2'b10} mode_t;

  mode_t            st, st_nxt;
  logic [W-1:0]     out_q;
  logic             slewing;
  logic [A-1:0]     acc;
  logic [HC_W-1:0]  ucnt;
  logic [LC_W-1:0]  lcnt;
  logic [LIM_W-1:0] hcnt;

  wire good       = ref_ok & lock_in;
  wire qual       = (lcnt == LC_W'(LOCK));
  wire hist_valid = (ucnt == HC_W'(HIST));
  wire upd        = (st == M_NORM) & tick & ref_ok;

  logic signed [A:0] dlt, dstep;
  assign dlt   = $signed({1'b0, loop_word, {S{1'b0}}}) - $signed({1'b0, acc});
  assign dstep = dlt >>> S;

  logic [LIM_W:0] hnext;
  assign hnext = {1'b0, hcnt} + (LIM_W+1)'(1);
  wire expire  = (st == M_HOLD) & tick & (hnext >= {1'b0, hold_limit});

  wire          up   = loop_word > out_q;
  wire [W-1:0]  gap  = up ? loop_word - out_q : out_q - loop_word;
  wire          near = gap <= slew_step;
  wire          snap = (slew_step == '0) | (out_q == loop_word);

  always_comb begin
    st_nxt = st;
    case (st)
      M_FREE:  if (qual) st_nxt = M_NORM;
      M_NORM:  if (!ref_ok) st_nxt = hist_valid ? M_HOLD : M_FREE;
      M_HOLD:  if (qual) st_nxt = M_NORM;
               else if (expire) st_nxt = M_FREE;
      default: st_nxt = M_FREE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st <= M_FREE;
    else        st <= st_nxt;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !good || st == M_NORM) lcnt <= '0;
    else if (tick && !qual)              lcnt <= lcnt + LC_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                               ucnt <= '0;
    else if (st_nxt == M_FREE && st != M_FREE) ucnt <= '0;
    else if (upd && !hist_valid)              ucnt <= ucnt + HC_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)    acc <= '0;
    else if (upd)  acc <= (ucnt == '0) ? {loop_word, {S{1'b0}}} : acc + dstep[A-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n || st != M_HOLD) hcnt <= '0;
    else if (tick)              hcnt <= hnext[LIM_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                              slewing <= 1'b0;
    else if (st != M_NORM && st_nxt == M_NORM) slewing <= 1'b1;
    else if (st == M_NORM && snap)           slewing <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) out_q <= NOMINAL;
    else begin
      case (st)
        M_NORM: begin
          if (!slewing || snap) out_q <= loop_word;
          else if (tick)        out_q <= near ? loop_word : (up ? out_q + slew_step : out_q - slew_step);
        end
        M_HOLD:  out_q <= acc[A-1:S];
        default: out_q <= NOMINAL;
      endcase
    end
  end

  assign freq_word = out_q;
  assign mode      = st;

  p_mode_code_r1: assert property (@(posedge clk) disable iff (!rst_n)
    mode != 2'b11);

  p_qual_entry_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == M_NORM && $past(st) != M_NORM) |-> $past(lcnt) == LC_W'(LOCK));

  p_hold_entry_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == M_HOLD && $past(st) != M_HOLD) |-> ($past(st) == M_NORM && $past(ucnt) == HC_W'(HIST)));

  p_short_history_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == M_NORM && !ref_ok && ucnt != HC_W'(HIST)) |=> st == M_FREE);

  p_timeout_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(st) == M_HOLD && st == M_FREE) |-> ucnt == '0);

  p_free_nominal_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(st) == M_FREE && st == M_FREE) |-> freq_word == NOMINAL);

  p_slew_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st == M_NORM && $past(st) == M_NORM && $past(slewing) && slew_step != '0 && $stable(slew_step))
    |-> (((freq_word >= $past(freq_word)) ? freq_word - $past(freq_word)
                                          : $past(freq_word) - freq_word) <= slew_step));

endmodule

// File: tb/clk_mode_ctrl_bench.sv
module clk_mode_ctrl_bench;
  localparam int W = 24;
  localparam int LIM_W = 16;
  localparam longint NOM = 64'h800000;

  logic clk = 0, rst_n = 0, ref_ok = 0, lock_in = 0, tick = 0;
  logic [W-1:0] loop_word = '0, slew_step = '0;
  logic [LIM_W-1:0] hold_limit = '0;
  logic [W-1:0] freq_word;
  logic [1:0] mode;

  int n_chk = 0, n_fail = 0;
  longint acc = 0;
  int ucnt = 0;
  bit done = 0;

  clk_mode_ctrl u_clk_mode_ctrl (
    .clk(clk), .rst_n(rst_n), .ref_ok(ref_ok), .lock_in(lock_in), .tick(tick),
    .loop_word(loop_word), .hold_limit(hold_limit), .slew_step(slew_step),
    .freq_word(freq_word), .mode(mode));

  always #2 clk = ~clk;

  task automatic check(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic tick_once();
    @(negedge clk); tick = 1;
    @(negedge clk); tick = 0;
    @(negedge clk);
  endtask

  task automatic norm_tick(input longint w);
    @(negedge clk); loop_word = W'(w); tick = 1;
    @(negedge clk); tick = 0;
    @(negedge clk);
    if (ucnt == 0) acc = w <<< 8;
    else acc = acc + (((w <<< 8) - acc) >>> 8);
    if (ucnt < 256) ucnt++;
  endtask

  task automatic qualify();
    ref_ok = 1; lock_in = 1;
    repeat (16) tick_once();
  endtask

  function automatic longint pat(input int i);
    return 64'h400000 + ((i * 37) % 101) - 50;
  endfunction

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    longint a, tgt, cur, st;
    int sgn;
    idle(5); rst_n = 1; idle(2);
    check("R1 reset mode", mode, 0);
    check("R7 reset word", freq_word, NOM);

    hold_limit = 3; slew_step = 0;
    ref_ok = 1; lock_in = 1; loop_word = W'(pat(0));
    repeat (15) tick_once();
    check("R2 15 ticks not enough", mode, 0);
    lock_in = 0; idle(1); lock_in = 1;
    repeat (15) tick_once();
    check("R2 glitch restarts count", mode, 0);
    check("R7 free word", freq_word, NOM);
    tick_once();
    check("R2 normal after 16", mode, 1);
    idle(2);
    check("R8 step zero snaps", freq_word, pat(0));
    loop_word = 24'h400123; idle(2);
    check("R9 tracks loop", freq_word, 64'h400123);

    for (int i = 0; i < 255; i++) norm_tick(pat(i));
    ref_ok = 0; idle(3);
    check("R5 255 updates gives free", mode, 0);
    check("R3 no history no holdover", freq_word, NOM);
    ucnt = 0;

    for (int lim = 1; lim <= 4; lim++) begin
      qualify();
      check("R2 requalify", mode, 1);
      for (int i = 0; i < 256; i++) norm_tick(pat(i + lim * 300));
      hold_limit = LIM_W'(lim);
      ref_ok = 0; idle(3);
      check("R3 holdover entry", mode, 2);
      check("R4 holdover average", freq_word, acc >>> 8);
      repeat (lim - 1) tick_once();
      check("R6 before limit", mode, 2);
      tick_once();
      check("R6 at limit", mode, 0);
      ucnt = 0;
    end

    qualify();
    for (int i = 0; i < 10; i++) norm_tick(pat(i));
    ref_ok = 0; idle(3);
    check("R6 history cleared", mode, 0);
    ucnt = 0;

    qualify();
    for (int i = 0; i < 256; i++) norm_tick(64'h300000);
    hold_limit = 1000;
    ref_ok = 0; idle(3);
    check("R3 hold for slew", mode, 2);
    check("R4 constant average", freq_word, 64'h300000);
    a = acc >>> 8;

    sgn = 1;
    foreach (st_list[k]) begin
      st = st_list[k];
      tgt = a + sgn * 5000;
      loop_word = W'(tgt); slew_step = W'(st);
      qualify();
      check("R2 hold exit", mode, 1);
      idle(2);
      check("R8 no jump on entry", freq_word, a);
      cur = a;
      while (cur != tgt) begin
        norm_tick(tgt);
        if (((tgt > cur) ? tgt - cur : cur - tgt) <= st) cur = tgt;
        else cur = (tgt > cur) ? cur + st : cur - st;
        check("R8 slew trajectory", freq_word, cur);
      end
      norm_tick(tgt);
      check("R9 settled", freq_word, tgt);
      ref_ok = 0; idle(3);
      check("R3 back to hold", mode, 2);
      check("R4 average after slew", freq_word, acc >>> 8);
      a = acc >>> 8;
      sgn = -sgn;
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  longint st_list[3] = '{256, 1000, 3333};
endmodule